// File: doc/BRIEF.md
# Event-Driven Task Scheduler

This block decides which task a processing core runs next. It holds two flag bits for each of up to sixteen tasks: a pending bit that says the task has work, and a hold bit that keeps the task from running. A task can start only when its pending bit is set and its hold bit is clear. While the core is idle, the scheduler picks one such task. Tasks marked urgent come first, and within each class the lowest index wins. The scheduler announces the pick with a one-cycle launch strobe and the task number, and it clears the pending bit of that task. When the core finishes a task it pulses `task_done`, and the next dispatch can follow on the next clock edge.

Flag changes come from three sources. The first is a command port, which lets a running task set the pending bit of any task, set its hold bit, or clear its hold bit. The second is the set of completion pulses from background threads: each thread has a programmable binding that names a target task and one action, either mark it pending or release its hold. The third is the not-empty status of hardware FIFOs: while a bound FIFO holds data, it marks its consumer task pending on every cycle. One completion that releases a hold and another that marks the same task pending make a two-way barrier that needs no counter. Trees of such barriers can join many threads.

Top module: `task_sched`

## Requirements
- R1: After reset every pending bit and every hold bit is clear, `busy` is 0, and no launch happens until an event arrives.
- R2: A task launches only while its pending bit is set and its hold bit is clear. A held task that is pending waits, and it launches once its hold is released.
- R3: A launch shows as `launch`=1 for exactly one cycle with the task number on `task_idx`, and it clears that task's pending bit. Without a new event the task does not launch again.
- R4: When several tasks of the same class are eligible, the lowest index launches first, and the rest follow in ascending order.
- R5: Every eligible task whose `prio_mask` bit is 1 launches before any eligible task whose bit is 0.
- R6: While `busy` is 1, nothing launches. A `task_done` pulse clears `busy` at the next edge, and an eligible task launches at the edge after that.
- R7: The command encoding on `cmd_op` is: 2'b01 marks `cmd_task` pending, 2'b10 releases its hold, 2'b11 holds it, and 2'b00 has no effect. An event applied at one edge lets a launch appear after the following edge.
- R8: A pulse on `thr_done[t]` applies the action bound to thread t to the task bound to thread t. The action is 0 for mark pending and 1 for release hold. A thread whose binding is disabled has no effect.
- R9: A held task becomes runnable only after both a release-hold completion and a mark-pending completion have arrived, in either order or in the same cycle.
- R10: While `fifo_ne[f]` is 1 and FIFO f is bound, the bound task is marked pending on every cycle, so it launches again after each `task_done`. Once the FIFO is empty, the task launches no more.
- R11: A mark-pending event and a hold event for the same task in the same cycle both take effect. A hold event and a release event in the same cycle leave the task held.
- R12: Events that mark the currently running task pending, including events in its own launch cycle, cause one more dispatch of that task after `task_done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_op | input | 2 | Command operation (nop, pend, release, hold) |
| cmd_task | input | TW | Target task of the command |
| thr_done | input | NUM_THREADS | Completion pulse for each background thread |
| fifo_ne | input | NUM_FIFOS | Not-empty status of each FIFO |
| prio_mask | input | NUM_TASKS | Urgent class marker for each task |
| bind_we | input | 1 | Write strobe for one binding entry |
| bind_fifo | input | 1 | 1 selects the FIFO table, 0 selects the thread table |
| bind_sel | input | SW | Index of the thread or FIFO being bound |
| bind_task | input | TW | Target task written into the binding |
| bind_act | input | 1 | Thread action: 0 mark pending, 1 release hold |
| bind_en | input | 1 | Enables the binding |
| task_done | input | 1 | The running task has finished |
| launch | output | 1 | One-cycle dispatch strobe |
| task_idx | output | TW | Index of the dispatched task |
| busy | output | 1 | A task is running |

## Verification
The assertions assume that `task_done` arrives only while a task is running, that `prio_mask` does not change across a dispatch decision, and that bindings are rewritten only between uses. The bench keeps to these assumptions. It pulses `task_done` only after it has seen a launch. It changes `prio_mask` only while the scheduler is idle with no pending task. It writes each binding before it fires the thread or raises the FIFO status that uses it. Flags are loaded while a long-running holder task keeps the core busy, so a sweep of task sets can be drained and compared in order against the order computed in the bench.

// File: rtl/sched_pkg.sv
package sched_pkg;

   typedef enum logic [1:0] {
      OP_NOP   = 2'b00,
      OP_PEND  = 2'b01,
      OP_FREE  = 2'b10,
      OP_HOLD  = 2'b11
   } sched_op_e;

   typedef enum logic {
      DONE_PEND = 1'b0,
      DONE_FREE = 1'b1
   } done_act_e;

endpackage

// File: rtl/sched_events.sv
module sched_events
   import sched_pkg::*;
#(
   parameter int NT  = 16,
   parameter int NTH = 9,
   parameter int NF  = 4,
   parameter int TW  = 4,
   parameter int SW  = 4
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [1:0]    cmd_op,
   input  logic [TW-1:0] cmd_task,
   input  logic [NTH-1:0] thr_done,
   input  logic [NF-1:0] fifo_ne,
   input  logic          bind_we,
   input  logic          bind_fifo,
   input  logic [SW-1:0] bind_sel,
   input  logic [TW-1:0] bind_task,
   input  logic          bind_act,
   input  logic          bind_en,
   output logic [NT-1:0] set_pend,
   output logic [NT-1:0] set_free,
   output logic [NT-1:0] set_hold
);

   function automatic logic [NT-1:0] dec(input logic [TW-1:0] t);
      return NT'(1) << t;
   endfunction

   logic [TW-1:0] thr_tgt_q  [NTH];
   done_act_e     thr_act_q  [NTH];
   logic [NTH-1:0] thr_en_q;
   logic [TW-1:0] fifo_tgt_q [NF];
   logic [NF-1:0] fifo_en_q;

   // binding table for thread completions
   for (genvar t = 0; t < NTH; t++) begin : g_thr
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            thr_tgt_q[t] <= '0;
            thr_act_q[t] <= DONE_PEND;
            thr_en_q[t]  <= 1'b0;
         end else if (bind_we && !bind_fifo && bind_sel == SW'(t)) begin
            thr_tgt_q[t] <= bind_task;
            thr_act_q[t] <= done_act_e'(bind_act);
            thr_en_q[t]  <= bind_en;
         end
      end
   end

   // binding table for FIFO consumers
   for (genvar f = 0; f < NF; f++) begin : g_fifo
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            fifo_tgt_q[f] <= '0;
            fifo_en_q[f]  <= 1'b0;
         end else if (bind_we && bind_fifo && bind_sel == SW'(f)) begin
            fifo_tgt_q[f] <= bind_task;
            fifo_en_q[f]  <= bind_en;
         end
      end
   end

   always_comb begin
      set_pend = '0;
      set_free = '0;
      set_hold = '0;
      unique case (sched_op_e'(cmd_op))
         OP_PEND: set_pend = dec(cmd_task);
         OP_FREE: set_free = dec(cmd_task);
         OP_HOLD: set_hold = dec(cmd_task);
         default: ;
      endcase
      for (int t = 0; t < NTH; t++) begin
         if (thr_done[t] && thr_en_q[t]) begin
            if (thr_act_q[t] == DONE_FREE) set_free = set_free | dec(thr_tgt_q[t]);
            else                           set_pend = set_pend | dec(thr_tgt_q[t]);
         end
      end
      for (int f = 0; f < NF; f++) begin
         if (fifo_ne[f] && fifo_en_q[f]) set_pend = set_pend | dec(fifo_tgt_q[f]);
      end
   end

endmodule

// File: rtl/sched_flags.sv
module sched_flags #(
   parameter int NT = 16
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [NT-1:0] set_pend,
   input  logic [NT-1:0] set_free,
   input  logic [NT-1:0] set_hold,
   input  logic [NT-1:0] clr_pend,
   output logic [NT-1:0] pend_q,
   output logic [NT-1:0] hold_q
);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pend_q <= '0;
         hold_q <= '0;
      end else begin
         pend_q <= (pend_q & ~clr_pend) | set_pend;
         hold_q <= (hold_q & ~set_free) | set_hold;
      end
   end

   // R11
   hold_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (set_hold != '0) |=> ((hold_q & $past(set_hold)) == $past(set_hold)));

   // R12
   pend_sticks_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (set_pend != '0) |=> ((pend_q & $past(set_pend)) == $past(set_pend)));

endmodule

// File: rtl/sched_pick.sv
module sched_pick #(
   parameter int NT      = 16,
   parameter int TW      = 4,
   parameter bit PRIO_EN = 1'b1
) (
   input  logic [NT-1:0] elig,
   input  logic [NT-1:0] prio,
   output logic          valid,
   output logic [TW-1:0] idx
);

   logic [NT-1:0] cand [2];
   logic          hit  [2];
   logic [TW-1:0] pos  [2];

   assign cand[0] = elig & prio;
   assign cand[1] = elig;

   for (genvar c = 0; c < 2; c++) begin : g_find
      always_comb begin
         hit[c] = 1'b0;
         pos[c] = '0;
         for (int i = NT - 1; i >= 0; i--) begin
            if (cand[c][i]) begin
               hit[c] = 1'b1;
               pos[c] = TW'(i);
            end
         end
      end
   end

   if (PRIO_EN) begin : g_two_class
      assign valid = hit[1];
      assign idx   = hit[0] ? pos[0] : pos[1];
   end else begin : g_flat
      logic unused_urgent;
      assign unused_urgent = hit[0] ^ (|pos[0]);
      assign valid = hit[1];
      assign idx   = pos[1];
   end

endmodule

// File: rtl/task_sched.sv
module task_sched
   import sched_pkg::*;
#(
   parameter int NUM_TASKS   = 16,
   parameter int NUM_THREADS = 9,
   parameter int NUM_FIFOS   = 4,
   parameter bit PRIO_EN     = 1'b1,
   localparam int TW   = $clog2(NUM_TASKS),
   localparam int MAXU = (NUM_THREADS > NUM_FIFOS) ? NUM_THREADS : NUM_FIFOS,
   localparam int SW   = (MAXU > 1) ? $clog2(MAXU) : 1
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic [1:0]             cmd_op,
   input  logic [TW-1:0]          cmd_task,
   input  logic [NUM_THREADS-1:0] thr_done,
   input  logic [NUM_FIFOS-1:0]   fifo_ne,
   input  logic [NUM_TASKS-1:0]   prio_mask,
   input  logic                   bind_we,
   input  logic                   bind_fifo,
   input  logic [SW-1:0]          bind_sel,
   input  logic [TW-1:0]          bind_task,
   input  logic                   bind_act,
   input  logic                   bind_en,
   input  logic                   task_done,
   output logic                   launch,
   output logic [TW-1:0]          task_idx,
   output logic                   busy
);

   if (NUM_TASKS < 2 || NUM_TASKS > 64) begin : g_bad_tasks
      $error("task_sched: NUM_TASKS must lie in 2..64");
   end
   if (NUM_THREADS < 1 || NUM_FIFOS < 1) begin : g_bad_src
      $error("task_sched: at least one thread and one FIFO are required");
   end

   function automatic logic [NUM_TASKS-1:0] dec(input logic [TW-1:0] t);
      return NUM_TASKS'(1) << t;
   endfunction

   logic [NUM_TASKS-1:0] set_pend, set_free, set_hold, clr_pend;
   logic [NUM_TASKS-1:0] pend_q, hold_q, elig;
   logic                 pick_valid, do_launch;
   logic [TW-1:0]        pick_idx;
   logic                 busy_q, launch_q;
   logic [TW-1:0]        idx_q;

   sched_events #(
      .NT(NUM_TASKS), .NTH(NUM_THREADS), .NF(NUM_FIFOS), .TW(TW), .SW(SW)
   ) u_events (
      .clk(clk), .rst_n(rst_n),
      .cmd_op(cmd_op), .cmd_task(cmd_task),
      .thr_done(thr_done), .fifo_ne(fifo_ne),
      .bind_we(bind_we), .bind_fifo(bind_fifo), .bind_sel(bind_sel),
      .bind_task(bind_task), .bind_act(bind_act), .bind_en(bind_en),
      .set_pend(set_pend), .set_free(set_free), .set_hold(set_hold)
   );

   sched_flags #(.NT(NUM_TASKS)) u_flags (
      .clk(clk), .rst_n(rst_n),
      .set_pend(set_pend), .set_free(set_free), .set_hold(set_hold),
      .clr_pend(clr_pend), .pend_q(pend_q), .hold_q(hold_q)
   );

   assign elig = pend_q & ~hold_q;

   sched_pick #(.NT(NUM_TASKS), .TW(TW), .PRIO_EN(PRIO_EN)) u_pick (
      .elig(elig), .prio(prio_mask), .valid(pick_valid), .idx(pick_idx)
   );

   assign do_launch = !busy_q && pick_valid;
   assign clr_pend  = do_launch ? dec(pick_idx) : '0;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy_q   <= 1'b0;
         launch_q <= 1'b0;
         idx_q    <= '0;
      end else begin
         launch_q <= do_launch;
         if (do_launch) begin
            busy_q <= 1'b1;
            idx_q  <= pick_idx;
         end else if (task_done) begin
            busy_q <= 1'b0;
         end
      end
   end

   assign launch   = launch_q;
   assign task_idx = idx_q;
   assign busy     = busy_q;

   // R3
   single_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
      launch |=> !launch);

   // R2
   launched_eligible_chk: assert property (@(posedge clk) disable iff (!rst_n)
      launch |-> (($past(elig) & dec(task_idx)) != '0));

   // R6
   idle_before_launch_chk: assert property (@(posedge clk) disable iff (!rst_n)
      launch |-> !$past(busy));

   // R6
   done_frees_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && task_done && !launch) |=> !busy);

   // R6
   busy_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> launch);

   // R5
   urgent_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (launch && PRIO_EN && (($past(elig) & $past(prio_mask)) != '0))
         |-> (($past(prio_mask) & dec(task_idx)) != '0));

endmodule

// File: tb/task_sched_bench.sv
module task_sched_bench;
   localparam int CLK_PERIOD = 10;
   localparam int NT  = 16;
   localparam int NTH = 9;
   localparam int NF  = 4;
   localparam int TW  = 4;
   localparam int SW  = 4;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic [1:0] cmd_op = 2'b00;
   logic [TW-1:0] cmd_task = '0;
   logic [NTH-1:0] thr_done = '0;
   logic [NF-1:0] fifo_ne = '0;
   logic [NT-1:0] prio_mask = '0;
   logic bind_we = 1'b0, bind_fifo = 1'b0, bind_act = 1'b0, bind_en = 1'b0;
   logic [SW-1:0] bind_sel = '0;
   logic [TW-1:0] bind_task = '0;
   logic task_done = 1'b0;
   logic launch, busy;
   logic [TW-1:0] task_idx;

   int checks = 0;
   int errors = 0;
   bit finished = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   task_sched u_task_sched (
      .clk(clk), .rst_n(rst_n), .cmd_op(cmd_op), .cmd_task(cmd_task),
      .thr_done(thr_done), .fifo_ne(fifo_ne), .prio_mask(prio_mask),
      .bind_we(bind_we), .bind_fifo(bind_fifo), .bind_sel(bind_sel),
      .bind_task(bind_task), .bind_act(bind_act), .bind_en(bind_en),
      .task_done(task_done), .launch(launch), .task_idx(task_idx), .busy(busy)
   );

   task automatic tick();
      @(posedge clk);
      #1;
   endtask

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic cmd(input logic [1:0] op, input int t);
      cmd_op = op; cmd_task = TW'(t);
      tick();
      cmd_op = 2'b00;
   endtask

   task automatic bind_cfg(input bit is_fifo, input int sel, input int t,
                           input bit act, input bit en);
      bind_we = 1'b1; bind_fifo = is_fifo; bind_sel = SW'(sel);
      bind_task = TW'(t); bind_act = act; bind_en = en;
      tick();
      bind_we = 1'b0;
   endtask

   task automatic pulse_thr(input int t);
      thr_done[t] = 1'b1;
      tick();
      thr_done = '0;
   endtask

   task automatic finish_task();
      task_done = 1'b1;
      tick();
      task_done = 1'b0;
   endtask

   task automatic expect_launch(input int t, input string req);
      tick();
      chk(launch === 1'b1 && task_idx == TW'(t), req,
          launch ? int'(task_idx) : -1, t);
   endtask

   task automatic expect_quiet(input int n, input string req);
      for (int i = 0; i < n; i++) begin
         tick();
         chk(launch === 1'b0, req, int'(launch), 0);
      end
   endtask

   initial begin
      #(CLK_PERIOD * 150000);
      if (!finished) begin
         errors++;
         checks++;
         $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (3) tick();
      rst_n = 1'b1;
      // R1: idle after reset
      chk(busy === 1'b0 && launch === 1'b0, "R1", int'(busy), 0);
      expect_quiet(4, "R1");

      // R7 / R3: pend command, one-cycle strobe, pending bit cleared
      cmd(2'b01, 5);
      chk(launch === 1'b0, "R7", int'(launch), 0);
      expect_launch(5, "R7");
      tick();
      chk(launch === 1'b0 && busy === 1'b1, "R3", int'(launch), 0);
      finish_task();
      expect_quiet(4, "R3");

      // R7: nop op has no effect
      cmd(2'b00, 3);
      expect_quiet(3, "R7");

      // R2: held task waits until released
      cmd(2'b11, 7);
      cmd(2'b01, 7);
      expect_quiet(4, "R2");
      cmd(2'b10, 7);
      expect_launch(7, "R2");
      finish_task();

      // R4 / R5: drain sweeps loaded behind a holder task
      for (int it = 0; it < 24; it++) begin
         logic [NT-1:0] m, p;
         string tag;
         m = 16'((it * 16'h2C5B + 16'h0137) & 16'h7FFF);
         p = (it < 8) ? '0 : 16'((it * 16'h03A7) ^ 16'h5A5A);
         tag = (it < 8) ? "R4" : "R5";
         prio_mask = p;
         cmd(2'b01, 15);
         expect_launch(15, tag);
         for (int b = 0; b < 15; b++) if (m[b]) cmd(2'b01, b);
         for (int pass = 0; pass < 2; pass++) begin
            for (int b = 0; b < 15; b++) begin
               if (m[b] && (p[b] == (pass == 0))) begin
                  finish_task();
                  expect_launch(b, tag);
               end
            end
         end
         finish_task();
         expect_quiet(2, tag);
         prio_mask = '0;
      end

      // R6: nothing launches while busy, exact timing after done
      cmd(2'b01, 2);
      expect_launch(2, "R6");
      cmd(2'b01, 1);
      for (int i = 0; i < 4; i++) begin
         tick();
         chk(launch === 1'b0 && busy === 1'b1, "R6", int'(launch), 0);
      end
      finish_task();
      chk(launch === 1'b0 && busy === 1'b0, "R6", int'(busy), 0);
      expect_launch(1, "R6");
      finish_task();

      // R8: thread bindings, pend action
      for (int t = 0; t < NTH; t++) begin
         bind_cfg(1'b0, t, t + 2, 1'b0, 1'b1);
         pulse_thr(t);
         expect_launch(t + 2, "R8");
         finish_task();
      end
      bind_cfg(1'b0, 6, 12, 1'b0, 1'b0);
      pulse_thr(6);
      expect_quiet(3, "R8");
      // R8: release action
      cmd(2'b11, 4);
      bind_cfg(1'b0, 3, 4, 1'b1, 1'b1);
      cmd(2'b01, 4);
      expect_quiet(2, "R8");
      pulse_thr(3);
      expect_launch(4, "R8");
      finish_task();

      // R9: two-way barrier in both orders and together
      bind_cfg(1'b0, 0, 9, 1'b1, 1'b1);
      bind_cfg(1'b0, 1, 9, 1'b0, 1'b1);
      cmd(2'b11, 9);
      pulse_thr(1);
      expect_quiet(3, "R9");
      pulse_thr(0);
      expect_launch(9, "R9");
      finish_task();
      cmd(2'b11, 9);
      pulse_thr(0);
      expect_quiet(3, "R9");
      pulse_thr(1);
      expect_launch(9, "R9");
      finish_task();
      cmd(2'b11, 9);
      thr_done = 9'b000000011;
      tick();
      thr_done = '0;
      expect_launch(9, "R9");
      finish_task();

      // R10: FIFO not-empty keeps waking its consumer
      bind_cfg(1'b1, 0, 13, 1'b0, 1'b0);
      fifo_ne[0] = 1'b1;
      expect_quiet(3, "R10");
      fifo_ne[0] = 1'b0;
      bind_cfg(1'b1, 2, 11, 1'b0, 1'b1);
      fifo_ne[2] = 1'b1;
      tick();
      expect_launch(11, "R10");
      finish_task();
      expect_launch(11, "R10");
      fifo_ne[2] = 1'b0;
      finish_task();
      expect_launch(11, "R10");
      finish_task();
      expect_quiet(4, "R10");

      // R11: pend and hold together; hold beats release
      bind_cfg(1'b0, 4, 6, 1'b0, 1'b1);
      cmd_op = 2'b11; cmd_task = 4'd6; thr_done[4] = 1'b1;
      tick();
      cmd_op = 2'b00; thr_done = '0;
      expect_quiet(3, "R11");
      cmd(2'b10, 6);
      expect_launch(6, "R11");
      finish_task();
      bind_cfg(1'b0, 5, 8, 1'b1, 1'b1);
      cmd_op = 2'b11; cmd_task = 4'd8; thr_done[5] = 1'b1;
      tick();
      cmd_op = 2'b00; thr_done = '0;
      cmd(2'b01, 8);
      expect_quiet(3, "R11");
      cmd(2'b10, 8);
      expect_launch(8, "R11");
      finish_task();

      // R12: running task re-pended runs once more
      cmd(2'b01, 3);
      expect_launch(3, "R12");
      cmd(2'b01, 3);
      finish_task();
      expect_launch(3, "R12");
      finish_task();
      expect_quiet(3, "R12");

      finished = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule